// File: doc/BRIEF.md
# Store-to-Load Forwarding Search

This block decides what happens to a load as it issues, based on the stores that are older than it and still in the store queue. It compares the load's byte range with every eligible older store in the same cycle. It then picks the youngest store whose range touches the load, and the result has one of three forms:

- **Forward:** the store covers every byte of the load, so the load takes its bytes from the store.
- **Stall:** the overlap is only partial, so the load must wait. The block reports which store entry blocks it and that store's sequence tag.
- **Miss:** no older store overlaps, so the load goes to memory.

The surrounding load/store unit supplies the store queue contents as flat vectors. It also supplies two pointers:

- the load's store-queue tail position, which is one past the youngest store older than the load;
- the writeback pointer, which marks the oldest store not yet written back.

Both pointers carry a wrap bit. The queue depth must be a power of two. The search is purely combinational. The clock and reset only qualify the embedded property checks.

Top module: `stlf_unit`

## Requirements
- R1: The load is forwarded when the selected store's range contains the load's range, the store is not atomic and the load is not load-linked. The load covers [addr, addr+bytes), and ld_size codes 0,1,2,3 mean 1,2,4,8 bytes. The forwarded data is the store's data shifted right by 8*(load address - store address) bits.
- R2: A forwarding store whose zero-fill flag is set supplies all-zero data instead of its data lanes.
- R3: A partial overlap with the selected store gives stall=1, fwd_hit=0 and miss=0. In that case stall_idx is the store's queue index and stall_seq is its sequence tag. Both are zero whenever stall is 0.
- R4: A load-linked load never forwards. Any overlap with the selected store, including full containment, gives a stall.
- R5: An atomic store never forwards. Any overlap with it gives a stall.
- R6: Stores with a byte count of zero, stores flagged strictly ordered and stores flagged cache-maintenance are skipped by the search.
- R7: Among the older stores that overlap, the youngest one (the one nearest the load's tail position) alone decides the outcome.
- R8: Only slots from the writeback pointer up to the load's tail position (exclusive, modulo the depth) are searched. Slots at or beyond the tail, and slots older than the writeback pointer, have no effect.
- R9: When no searched store overlaps, miss=1 in the same cycle, with fwd_hit=0, stall=0 and fwd_data=0.
- R10: With ld_valid=1, exactly one of fwd_hit, stall and miss is 1. With ld_valid=0, all three are 0 and so are the data, index and tag outputs.
- R11: Forwarded bytes beyond the load size read as zero.
- R12: Range ends are exclusive, so a store that ends exactly where the load begins, or begins exactly where the load ends, does not overlap it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to sample the embedded checks |
| rst_n | input | 1 | Active-low reset, disables checks |
| ld_valid | input | 1 | Load is issuing this cycle |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | 2 | Load size code (1,2,4,8 bytes) |
| ld_locked | input | 1 | Load is load-linked |
| ld_sq_tail | input | IDX_W+1 | Slot after the youngest older store, with wrap bit |
| sq_wb_ptr | input | IDX_W+1 | Oldest store not yet written back, with wrap bit |
| sq_addr | input | SQ_DEPTH*ADDR_W | Store addresses, entry i at bits i*ADDR_W |
| sq_bytes | input | SQ_DEPTH*4 | Store byte counts, 0 to 8 |
| sq_data | input | SQ_DEPTH*64 | Store data, little-endian byte lanes |
| sq_seq | input | SQ_DEPTH*SEQ_W | Store sequence tags |
| sq_atomic | input | SQ_DEPTH | Store is atomic |
| sq_strict | input | SQ_DEPTH | Store is strictly ordered |
| sq_cmo | input | SQ_DEPTH | Store is a cache-maintenance operation |
| sq_zero | input | SQ_DEPTH | Store carries no data (zero fill) |
| fwd_hit | output | 1 | Load is satisfied from a store |
| fwd_data | output | 64 | Forwarded load data, zero-extended |
| stall | output | 1 | Load blocked by a partial overlap |
| stall_idx | output | IDX_W | Queue index of the blocking store |
| stall_seq | output | SEQ_W | Sequence tag of the blocking store |
| miss | output | 1 | No overlap; load goes to memory |

## Verification
Every result of this block is combinational, so all outputs are due in the same cycle as the load and store-queue inputs that produce them. The bench drives new inputs just after a falling edge and samples all outputs one nanosecond later, well before the next rising edge. It compares them with a behavioural model that walks the queue from youngest to oldest. The embedded properties sample the same settled values on the rising edge that follows.

// File: rtl/stlf_pkg.sv
`timescale 1ns/1ps
package stlf_pkg;
  localparam int unsigned LANE_BYTES = 8;
  localparam int unsigned LANE_W     = LANE_BYTES * 8;
  localparam int unsigned SZ_W       = 4;

  typedef logic [SZ_W-1:0] nbytes_t;

  typedef struct packed {
    logic full;
    logic part;
  } cover_t;

  function automatic nbytes_t size_code_bytes(input logic [1:0] code);
    return nbytes_t'(1) << code;
  endfunction
endpackage

// File: rtl/stlf_cover_check.sv
`timescale 1ns/1ps
module stlf_cover_check
  import stlf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] ld_addr,
  input  nbytes_t           ld_bytes,
  input  logic              ld_locked,
  input  logic [ADDR_W-1:0] st_addr,
  input  nbytes_t           st_bytes,
  input  logic              st_atomic,
  input  logic              st_strict,
  input  logic              st_cmo,
  output cover_t            cov,
  output logic [2:0]        byte_ofs
);
  localparam int unsigned EW = ADDR_W + 1;

  logic [EW-1:0] l_lo, l_hi, s_lo, s_hi;
  logic eligible, lo_in, hi_in, start_in, end_in, touch;

  always_comb begin
    l_lo     = {1'b0, ld_addr};
    l_hi     = l_lo + EW'(ld_bytes);
    s_lo     = {1'b0, st_addr};
    s_hi     = s_lo + EW'(st_bytes);
    eligible = (st_bytes != '0) && !st_strict && !st_cmo;
    lo_in    = l_lo >= s_lo;
    hi_in    = l_hi <= s_hi;
    start_in = l_lo < s_hi;
    end_in   = l_hi > s_lo;
    if (ld_locked || st_atomic) begin
      touch = (lo_in || end_in) && (hi_in || start_in);
    end else begin
      touch = (lo_in && start_in) || (hi_in && end_in) || (start_in && end_in);
    end
    cov.full = eligible && lo_in && hi_in && !st_atomic && !ld_locked;
    cov.part = eligible && touch && !cov.full;
    byte_ofs = ld_addr[2:0] - st_addr[2:0];
  end
endmodule

// File: rtl/stlf_age_pick.sv
`timescale 1ns/1ps
module stlf_age_pick #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned PTR_W = IDX_W + 1
) (
  input  logic [DEPTH-1:0] hit,
  input  logic [PTR_W-1:0] tail_ptr,
  input  logic [PTR_W-1:0] wb_ptr,
  output logic             found,
  output logic [IDX_W-1:0] pick_idx
);
  logic [PTR_W-1:0] span;
  logic [IDX_W-1:0] slot;

  always_comb begin
    span     = tail_ptr - wb_ptr;
    found    = 1'b0;
    pick_idx = '0;
    slot     = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = tail_ptr[IDX_W-1:0] - IDX_W'(k + 1);
      if ((PTR_W'(k) < span) && !found && hit[slot]) begin
        found    = 1'b1;
        pick_idx = slot;
      end
    end
  end
endmodule

// File: rtl/stlf_lane_align.sv
`timescale 1ns/1ps
module stlf_lane_align
  import stlf_pkg::*;
(
  input  logic [LANE_W-1:0] st_data,
  input  logic [2:0]        ofs,
  input  nbytes_t           ld_bytes,
  input  logic              zero_fill,
  output logic [LANE_W-1:0] ld_data
);
  logic [LANE_W-1:0] shifted;

  always_comb begin
    shifted = st_data >> {ofs, 3'b000};
    for (int b = 0; b < LANE_BYTES; b++) begin
      ld_data[b*8 +: 8] = (!zero_fill && (SZ_W'(b) < ld_bytes)) ? shifted[b*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/stlf_unit.sv
`timescale 1ns/1ps
module stlf_unit
  import stlf_pkg::*;
#(
  parameter int unsigned SQ_DEPTH = 8,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SEQ_W    = 16,
  localparam int unsigned IDX_W   = $clog2(SQ_DEPTH),
  localparam int unsigned PTR_W   = IDX_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ld_valid,
  input  logic [ADDR_W-1:0]            ld_addr,
  input  logic [1:0]                   ld_size,
  input  logic                         ld_locked,
  input  logic [PTR_W-1:0]             ld_sq_tail,
  input  logic [PTR_W-1:0]             sq_wb_ptr,
  input  logic [SQ_DEPTH*ADDR_W-1:0]   sq_addr,
  input  logic [SQ_DEPTH*SZ_W-1:0]     sq_bytes,
  input  logic [SQ_DEPTH*LANE_W-1:0]   sq_data,
  input  logic [SQ_DEPTH*SEQ_W-1:0]    sq_seq,
  input  logic [SQ_DEPTH-1:0]          sq_atomic,
  input  logic [SQ_DEPTH-1:0]          sq_strict,
  input  logic [SQ_DEPTH-1:0]          sq_cmo,
  input  logic [SQ_DEPTH-1:0]          sq_zero,
  output logic                         fwd_hit,
  output logic [LANE_W-1:0]            fwd_data,
  output logic                         stall,
  output logic [IDX_W-1:0]             stall_idx,
  output logic [SEQ_W-1:0]             stall_seq,
  output logic                         miss
);
  nbytes_t           ld_bytes;
  cover_t            cov_a [SQ_DEPTH];
  logic [2:0]        ofs_a [SQ_DEPTH];
  logic [SQ_DEPTH-1:0] hit_vec;
  logic              found;
  logic [IDX_W-1:0]  pick_idx;
  logic              sel_full;
  logic [LANE_W-1:0] sel_data;
  logic [LANE_W-1:0] lane_data;

  assign ld_bytes = size_code_bytes(ld_size);

  for (genvar g = 0; g < SQ_DEPTH; g++) begin : g_entry
    stlf_cover_check #(.ADDR_W(ADDR_W)) u_cover (
      .ld_addr   (ld_addr),
      .ld_bytes  (ld_bytes),
      .ld_locked (ld_locked),
      .st_addr   (sq_addr[g*ADDR_W +: ADDR_W]),
      .st_bytes  (sq_bytes[g*SZ_W +: SZ_W]),
      .st_atomic (sq_atomic[g]),
      .st_strict (sq_strict[g]),
      .st_cmo    (sq_cmo[g]),
      .cov       (cov_a[g]),
      .byte_ofs  (ofs_a[g])
    );
    assign hit_vec[g] = cov_a[g].full | cov_a[g].part;
  end

  stlf_age_pick #(.DEPTH(SQ_DEPTH)) u_pick (
    .hit      (hit_vec),
    .tail_ptr (ld_sq_tail),
    .wb_ptr   (sq_wb_ptr),
    .found    (found),
    .pick_idx (pick_idx)
  );

  assign sel_full = cov_a[pick_idx].full;
  assign sel_data = sq_data[pick_idx*LANE_W +: LANE_W];

  stlf_lane_align u_align (
    .st_data   (sel_data),
    .ofs       (ofs_a[pick_idx]),
    .ld_bytes  (ld_bytes),
    .zero_fill (sq_zero[pick_idx]),
    .ld_data   (lane_data)
  );

  always_comb begin
    fwd_hit   = ld_valid && found && sel_full;
    stall     = ld_valid && found && !sel_full;
    miss      = ld_valid && !found;
    fwd_data  = fwd_hit ? lane_data : '0;
    stall_idx = stall ? pick_idx : '0;
    stall_seq = stall ? sq_seq[pick_idx*SEQ_W +: SEQ_W] : '0;
  end

  // independent window arithmetic for the checks
  logic [IDX_W-1:0] chk_age;
  logic [PTR_W-1:0] chk_span;
  assign chk_age  = ld_sq_tail[IDX_W-1:0] - IDX_W'(1) - stall_idx;
  assign chk_span = ld_sq_tail - sq_wb_ptr;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> ($countones({fwd_hit, stall, miss}) == 1)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> (!fwd_hit && !stall && !miss && fwd_data == '0)); // R10
  AST_NO_FWD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> !ld_locked); // R4
  AST_NO_FWD_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> !sq_atomic[pick_idx]); // R5
  AST_STALL_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (sq_bytes[stall_idx*SZ_W +: SZ_W] != '0 && !sq_strict[stall_idx] && !sq_cmo[stall_idx])); // R6
  AST_STALL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ({1'b0, chk_age} < chk_span)); // R8
endmodule

// File: tb/tb_stlf_unit.sv
`timescale 1ns/1ps
module tb_stlf_unit;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic [31:0] s_addr [N];
  logic [3:0]  s_size [N];
  logic [63:0] s_data [N];
  logic [15:0] s_seq  [N];
  logic        s_atom [N];
  logic        s_strict [N];
  logic        s_cmo  [N];
  logic        s_zero [N];

  logic        l_valid;
  logic [31:0] l_addr;
  logic [1:0]  l_size;
  logic        l_locked;
  logic [3:0]  l_tail;
  logic [3:0]  l_wb;

  logic [N*32-1:0] p_addr;
  logic [N*4-1:0]  p_size;
  logic [N*64-1:0] p_data;
  logic [N*16-1:0] p_seq;
  logic [N-1:0]    p_atom, p_strict, p_cmo, p_zero;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      p_addr[i*32 +: 32] = s_addr[i];
      p_size[i*4 +: 4]   = s_size[i];
      p_data[i*64 +: 64] = s_data[i];
      p_seq[i*16 +: 16]  = s_seq[i];
      p_atom[i]   = s_atom[i];
      p_strict[i] = s_strict[i];
      p_cmo[i]    = s_cmo[i];
      p_zero[i]   = s_zero[i];
    end
  end

  logic        fwd_hit, stall, miss;
  logic [63:0] fwd_data;
  logic [2:0]  stall_idx;
  logic [15:0] stall_seq;

  stlf_unit dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(l_valid), .ld_addr(l_addr), .ld_size(l_size),
    .ld_locked(l_locked), .ld_sq_tail(l_tail), .sq_wb_ptr(l_wb),
    .sq_addr(p_addr), .sq_bytes(p_size), .sq_data(p_data), .sq_seq(p_seq),
    .sq_atomic(p_atom), .sq_strict(p_strict), .sq_cmo(p_cmo), .sq_zero(p_zero),
    .fwd_hit(fwd_hit), .fwd_data(fwd_data), .stall(stall), .stall_idx(stall_idx),
    .stall_seq(stall_seq), .miss(miss)
  );

  int total = 0;
  int bad = 0;

  task automatic model(output bit e_fwd, output bit e_stall, output bit e_miss,
                       output logic [63:0] e_data, output logic [2:0] e_idx,
                       output logic [15:0] e_seq);
    int cnt;
    e_fwd = 0; e_stall = 0; e_miss = 0; e_data = '0; e_idx = '0; e_seq = '0;
    if (!l_valid) return;
    cnt = (int'(l_tail) - int'(l_wb) + 16) % 16;
    for (int k = 0; k < cnt; k++) begin
      int idx;
      longint ls, le, ss, se;
      bit lo, up, si, ei, full, part;
      idx = (int'(l_tail) % N - 1 - k + 2 * N) % N;
      if (s_size[idx] == 0 || s_strict[idx] || s_cmo[idx]) continue;
      ls = longint'(l_addr); le = ls + (longint'(1) << l_size);
      ss = longint'(s_addr[idx]); se = ss + longint'(s_size[idx]);
      lo = ls >= ss; up = le <= se; si = ls < se; ei = le > ss;
      full = lo && up && !s_atom[idx] && !l_locked;
      if (l_locked || s_atom[idx]) part = (lo || ei) && (up || si);
      else part = (lo && si) || (up && ei) || (si && ei);
      if (full) begin
        e_fwd = 1;
        for (int b = 0; b < (1 << l_size); b++) begin
          longint sh;
          sh = 8 * ((ls - ss) + b);
          e_data[b*8 +: 8] = s_zero[idx] ? 8'h00 : 8'((s_data[idx] >> sh) & 64'hFF);
        end
        return;
      end
      if (part) begin
        e_stall = 1; e_idx = 3'(idx); e_seq = s_seq[idx];
        return;
      end
    end
    e_miss = 1;
  endtask

  task automatic check(input string tag);
    bit ef, es, em;
    logic [63:0] ed;
    logic [2:0] ei;
    logic [15:0] eq;
    model(ef, es, em, ed, ei, eq);
    total++;
    if (fwd_hit !== ef || stall !== es || miss !== em || fwd_data !== ed ||
        stall_idx !== ei || stall_seq !== eq) begin
      bad++;
      $display("FAIL %s: actual fwd=%0b stall=%0b miss=%0b data=%h idx=%0d seq=%h expected fwd=%0b stall=%0b miss=%0b data=%h idx=%0d seq=%h",
               tag, fwd_hit, stall, miss, fwd_data, stall_idx, stall_seq, ef, es, em, ed, ei, eq);
    end
  endtask

  // inputs are set just after a falling edge; sample 1 ns later
  task automatic go(input string tag);
    #1;
    check(tag);
    @(negedge clk);
  endtask

  task automatic clear_q();
    for (int i = 0; i < N; i++) begin
      s_addr[i] = '0; s_size[i] = '0; s_data[i] = '0; s_seq[i] = 16'h0A00 + 16'(i);
      s_atom[i] = 0; s_strict[i] = 0; s_cmo[i] = 0; s_zero[i] = 0;
    end
  endtask

  task automatic put(input int i, input logic [31:0] a, input logic [3:0] sz, input logic [63:0] d,
                     input bit atom = 0, input bit strict = 0, input bit cmo = 0, input bit zero = 0);
    s_addr[i] = a; s_size[i] = sz; s_data[i] = d;
    s_atom[i] = atom; s_strict[i] = strict; s_cmo[i] = cmo; s_zero[i] = zero;
  endtask

  task automatic load(input logic [31:0] a, input logic [1:0] code, input bit lk,
                      input logic [3:0] tail, input logic [3:0] wb);
    l_valid = 1; l_addr = a; l_size = code; l_locked = lk; l_tail = tail; l_wb = wb;
  endtask

  localparam logic [63:0] PAT = 64'h8877665544332211;

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; l_valid = 0; l_addr = '0; l_size = '0; l_locked = 0; l_tail = '0; l_wb = '0;
    clear_q();
    @(negedge clk);
    go("R10 reset quiet");
    rst_n = 1;
    @(negedge clk);

    // R1 forward with offset
    clear_q(); put(0, 32'h100, 8, PAT); load(32'h102, 2, 0, 1, 0); go("R1 offset forward");
    load(32'h100, 3, 0, 1, 0); go("R1 full lane forward");
    // R11 narrow loads
    load(32'h107, 0, 0, 1, 0); go("R11 byte forward");
    load(32'h104, 1, 0, 1, 0); go("R11 half forward");
    // R2 zero fill
    put(0, 32'h100, 8, PAT, 0, 0, 0, 1); load(32'h100, 3, 0, 1, 0); go("R2 zero fill");
    // R3 partial overlaps
    clear_q(); put(2, 32'h104, 8, PAT); load(32'h100, 3, 0, 3, 0); go("R3 partial high");
    put(2, 32'h102, 2, PAT); go("R3 load contains store");
    put(2, 32'h0FE, 4, PAT); load(32'h100, 2, 0, 3, 0); go("R3 partial low");
    // R4 load-linked
    clear_q(); put(1, 32'h100, 8, PAT); load(32'h100, 2, 1, 2, 0); go("R4 locked stall");
    // R5 atomic
    put(1, 32'h100, 8, PAT, 1); load(32'h100, 2, 0, 2, 0); go("R5 atomic stall");
    // R6 skipped entries
    clear_q(); put(0, 32'h100, 8, PAT); put(1, 32'h100, 0, 64'hFF);
    put(2, 32'h100, 8, 64'hAAAA, 0, 1); put(3, 32'h100, 8, 64'hBBBB, 0, 0, 1);
    load(32'h100, 3, 0, 4, 0); go("R6 skip zero/strict/cmo");
    // R7 youngest wins
    clear_q(); put(0, 32'h100, 8, PAT); put(1, 32'h100, 4, 64'hCAFEF00D);
    load(32'h100, 2, 0, 2, 0); go("R7 youngest full wins");
    put(1, 32'h102, 4, 64'h1); go("R7 youngest partial stalls");
    // R8 window
    clear_q(); put(1, 32'h100, 8, PAT); load(32'h100, 2, 0, 1, 0); go("R8 younger store ignored");
    clear_q(); put(0, 32'h100, 8, PAT); load(32'h100, 2, 0, 3, 1); go("R8 written-back ignored");
    clear_q(); put(7, 32'h100, 8, PAT); load(32'h100, 2, 0, 10, 6); go("R8 wrapped window");
    put(7, 32'h0, 0, 0); put(2, 32'h100, 8, PAT); go("R8 outside wrapped window");
    // R9 miss
    clear_q(); put(0, 32'h200, 8, PAT); load(32'h100, 3, 0, 1, 0); go("R9 no overlap miss");
    // R12 exclusive ends
    clear_q(); put(0, 32'h100, 4, PAT); load(32'h104, 2, 0, 1, 0); go("R12 store ends at load");
    load(32'h0FC, 2, 0, 1, 0); go("R12 load ends at store");
    // R10 idle
    l_valid = 0; go("R10 idle quiet");

    for (int c = 0; c < 2000; c++) begin
      for (int i = 0; i < N; i++) begin
        put(i, 32'h100 + 32'($urandom % 24), 4'($urandom % 9),
            {$urandom, $urandom}, ($urandom % 8) == 0, ($urandom % 10) == 0,
            ($urandom % 10) == 0, ($urandom % 6) == 0);
      end
      l_wb = 4'($urandom % 16);
      load(32'h100 + 32'($urandom % 24), 2'($urandom % 4), ($urandom % 6) == 0,
           4'(l_wb + 4'($urandom % 9)), l_wb);
      l_valid = ($urandom % 8) != 0;
      go("R10 random mix");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule